// File: doc/BRIEF.md
# Tiled Watermark Embedder

This block adds an invisible, payload-dependent watermark to a raster video stream one pixel at a time. A small square noise tile is repeated over the whole frame. Two position counters track where the current pixel sits inside that tile, and both wrap at the tile edge. For each pixel the block looks up the noise tile twice. The first look-up is at the pixel's own tile position. The second is at a position shifted by a payload-selected amount, and that shift wraps around the tile in both directions. The second value is subtracted from the first, so the payload is encoded only by the relative shift between two copies of one pattern.

The base sample is scaled by a per-pixel strength. That strength is the local masking value from an upstream filter multiplied by a global gain. The scaled sample is added to the incoming pixel and the result is clamped to the pixel range. Pixels flow through a two-stage pipeline and are never stalled. A start-of-frame flag and an end-of-line flag keep the tile position aligned to the raster.

Top module: `wm_tile_embedder`

## Requirements
- R1: While `rst_n` is low, the next clock edge leaves `out_valid` at 0 and `out_pixel` at 0. Reset also clears both tile counters to row 0, column 0.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and `out_pixel` carries the result for that input.
- R3: Noise table entry i (i = row*8 + col on the 8x8 tile) is ((5*i + 3) mod 16) - 8, a signed value from -8 to 7.
- R4: A valid pixel with `in_sof` high sits at row 0, column 0. Each valid pixel advances the column modulo 8. A valid pixel with `in_eol` high returns the column to 0 for the next pixel and advances the row modulo 8.
- R5: The second look-up uses column (col + 2*`payload[1:0]`) mod 8 and row (row + 2*`payload[3:2]`) mod 8, so shifts fall on a grid of two pixels.
- R6: The base sample is the first noise value minus the second. With `payload` = 0 the base sample is 0, so the output pixel equals the input pixel.
- R7: The pixel strength is (`in_depth` * `gain`) >> 8. With `gain` = 0 the output pixel equals the input pixel.
- R8: `out_pixel` = clamp(`in_pixel` + base * strength, 0, 255).
- R9: A cycle with `in_valid` low advances neither counter and produces a cycle with `out_valid` low two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | This pixel starts a frame |
| in_eol | input | 1 | This pixel ends a line |
| in_pixel | input | 8 | Original pixel value |
| in_depth | input | 8 | Local masking value from the upstream filter |
| gain | input | 8 | Global embedding gain |
| payload | input | 4 | Tile shift: bits 1:0 column step, bits 3:2 row step |
| out_valid | output | 1 | Output pixel present |
| out_pixel | output | 8 | Watermarked, clamped pixel |

## Verification
The bound checker tests some properties on every clocked cycle. It checks the idle state after reset and the two-cycle valid delay. It also checks that the pixel passes through unchanged whenever the payload or the gain was zero. The bench's scenarios must cover the rest. That includes the exact noise values and wrapped offsets. It also includes the tile walk across line ends, frame starts and gaps, the strength scaling, and clamping at both range ends. The bench compares these against a model computed from the stated formulas.

// File: rtl/wm_tile_embedder.sv
module wm_tile_embedder #(
  parameter int PIX_W      = 8,
  parameter int DEPTH_W    = 8,
  parameter int GAIN_W     = 8,
  parameter int GAIN_SHIFT = 8,
  parameter int TILE_LOG   = 3,
  parameter int GRID_LOG   = 1,
  parameter int NOISE_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic                            in_sof,
  input  logic                            in_eol,
  input  logic [PIX_W-1:0]                in_pixel,
  input  logic [DEPTH_W-1:0]              in_depth,
  input  logic [GAIN_W-1:0]               gain,
  input  logic [2*(TILE_LOG-GRID_LOG)-1:0] payload,
  output logic                            out_valid,
  output logic [PIX_W-1:0]                out_pixel
);
  localparam int PAY_W  = TILE_LOG - GRID_LOG;
  localparam int IDX_W  = 2 * TILE_LOG;
  localparam int BASE_W = NOISE_W + 1;
  localparam int PROD_W = DEPTH_W + GAIN_W;
  localparam int STR_W  = PROD_W - GAIN_SHIFT;
  localparam int WM_W   = BASE_W + STR_W + 1;
  localparam int SUM_W  = WM_W + 1;
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  function automatic logic signed [NOISE_W-1:0] noise_at(input logic [IDX_W-1:0] idx);
    logic [IDX_W+2:0] t;
    t = ({3'b000, idx} << 2) + {3'b000, idx} + (IDX_W+3)'(3);
    return {~t[NOISE_W-1], t[NOISE_W-2:0]};
  endfunction

  logic [TILE_LOG-1:0] col_q, row_q;
  logic [TILE_LOG-1:0] cur_col, cur_row, sh_col, sh_row;
  logic [TILE_LOG-1:0] off_col, off_row;
  logic signed [NOISE_W-1:0] n_own, n_shift;
  logic signed [BASE_W-1:0]  base;
  logic [PROD_W-1:0]         prod;

  assign cur_col = in_sof ? '0 : col_q;
  assign cur_row = in_sof ? '0 : row_q;
  assign off_col = {payload[PAY_W-1:0], {GRID_LOG{1'b0}}};
  assign off_row = {payload[2*PAY_W-1:PAY_W], {GRID_LOG{1'b0}}};
  assign sh_col  = cur_col + off_col;
  assign sh_row  = cur_row + off_row;
  assign n_own   = noise_at({cur_row, cur_col});
  assign n_shift = noise_at({sh_row, sh_col});
  assign base    = {n_own[NOISE_W-1], n_own} - {n_shift[NOISE_W-1], n_shift};
  assign prod    = in_depth * gain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (in_valid) begin
      col_q <= in_eol ? '0 : cur_col + 1'b1;
      row_q <= in_eol ? cur_row + 1'b1 : cur_row;
    end
  end

  logic                     s1_valid;
  logic [PIX_W-1:0]         s1_pix;
  logic signed [BASE_W-1:0] s1_base;
  logic [STR_W-1:0]         s1_str;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_base  <= '0;
      s1_str   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_pix  <= in_pixel;
        s1_base <= base;
        s1_str  <= prod[PROD_W-1:GAIN_SHIFT];
      end
    end
  end

  logic signed [WM_W-1:0]  wm;
  logic signed [SUM_W-1:0] sum;
  logic [PIX_W-1:0]        clamped;

  assign wm  = s1_base * $signed({1'b0, s1_str});
  assign sum = $signed({{(SUM_W-PIX_W){1'b0}}, s1_pix}) + $signed({wm[WM_W-1], wm});
  assign clamped = (sum < 0) ? '0 : (sum > PIX_MAX) ? '1 : sum[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_pixel <= clamped;
    end
  end
endmodule

// File: rtl/wm_tile_embedder_chk.sv
module wm_tile_embedder_chk #(
  parameter int PIX_W = 8,
  parameter int GAIN_W = 8,
  parameter int PAY_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PIX_W-1:0]  in_pixel,
  input logic [GAIN_W-1:0] gain,
  input logic [PAY_W-1:0]  payload,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_pixel
);
  logic [1:0] since_rst;
  logic warm;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end
  assign warm = (since_rst >= 2'd2);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_pixel == '0));
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 2)));
  // R6
  zero_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(payload, 2) == '0) |-> (out_pixel == $past(in_pixel, 2)));
  // R7
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && $past(gain, 2) == '0) |-> (out_pixel == $past(in_pixel, 2)));
endmodule

bind wm_tile_embedder wm_tile_embedder_chk #(
  .PIX_W(PIX_W), .GAIN_W(GAIN_W), .PAY_W(2*(TILE_LOG-GRID_LOG))
) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
  .gain(gain), .payload(payload), .out_valid(out_valid), .out_pixel(out_pixel)
);

// File: tb/wm_tile_embedder_test.sv
module wm_tile_embedder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0] in_pixel = '0, in_depth = '0, gain = '0;
  logic [3:0] payload = '0;
  logic out_valid;
  logic [7:0] out_pixel;

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_tile_embedder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_pixel(in_pixel), .in_depth(in_depth), .gain(gain), .payload(payload),
    .out_valid(out_valid), .out_pixel(out_pixel)
  );

  int checks = 0, errors = 0;
  int mrow = 0, mcol = 0;
  logic ev [2];
  int   ep [2];
  string et [2];
  bit done = 1'b0;

  // {valid, sof, eol, payload, gain, depth, pixel}
  localparam logic [30:0] VEC [16] = '{
    {1'b1,1'b1,1'b0,4'h1,8'd128,8'd16,8'd100},
    {1'b1,1'b0,1'b0,4'h2,8'd200,8'd40,8'd90},
    {1'b1,1'b0,1'b0,4'h3,8'd255,8'd255,8'd128},
    {1'b1,1'b0,1'b0,4'h4,8'd64,8'd32,8'd200},
    {1'b0,1'b0,1'b0,4'h5,8'd99,8'd99,8'd1},
    {1'b1,1'b0,1'b1,4'h5,8'd100,8'd50,8'd60},
    {1'b1,1'b0,1'b0,4'hF,8'd255,8'd255,8'd250},
    {1'b1,1'b0,1'b0,4'hA,8'd255,8'd255,8'd5},
    {1'b1,1'b0,1'b0,4'h7,8'd17,8'd240,8'd77},
    {1'b1,1'b0,1'b0,4'hC,8'd128,8'd128,8'd0},
    {1'b1,1'b0,1'b0,4'h9,8'd128,8'd128,8'd255},
    {1'b1,1'b0,1'b1,4'h6,8'd30,8'd90,8'd140},
    {1'b1,1'b1,1'b0,4'h3,8'd80,8'd200,8'd33},
    {1'b0,1'b0,1'b0,4'h0,8'd0,8'd0,8'd0},
    {1'b1,1'b0,1'b0,4'hE,8'd150,8'd70,8'd180},
    {1'b1,1'b0,1'b0,4'hB,8'd255,8'd8,8'd20}
  };

  function automatic int nz(input int i);
    return ((5*i + 3) % 16) - 8;
  endfunction

  function automatic int model(input bit sof, input int pay, input int g, input int d, input int p);
    int r, c, a, b, s;
    r = sof ? 0 : mrow;
    c = sof ? 0 : mcol;
    a = r*8 + c;
    b = ((r + 2*((pay >> 2) & 3)) % 8)*8 + ((c + 2*(pay & 3)) % 8);
    s = p + (nz(a) - nz(b)) * ((d*g) >> 8);
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic step(input bit v, input bit sof, input bit eol, input int pay,
                      input int g, input int d, input int p, input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== ev[1]) begin
      errors++;
      $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, ev[1]);
    end
    if (ev[1]) begin
      checks++;
      if (out_pixel !== ep[1][7:0]) begin
        errors++;
        $display("FAIL %s out_pixel actual %0d expected %0d", et[1], out_pixel, ep[1]);
      end
    end
    ev[1] = ev[0]; ep[1] = ep[0]; et[1] = et[0];
    in_valid = v; in_sof = sof; in_eol = eol; payload = pay[3:0];
    gain = g[7:0]; in_depth = d[7:0]; in_pixel = p[7:0];
    ev[0] = v; et[0] = tag;
    ep[0] = model(sof, pay, g, d, p);
    if (v) begin
      if (sof) begin mrow = 0; mcol = 0; end
      if (eol) begin mcol = 0; mrow = (mrow + 1) % 8; end
      else mcol = (mcol + 1) % 8;
    end
  endtask

  task automatic flush();
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_pixel !== 8'd0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %0b/%0d expected 0/0", out_valid, out_pixel);
    end
    rst_n = 1'b1;
    mrow = 0; mcol = 0;
    ev[0] = 0; ev[1] = 0; ep[0] = 0; ep[1] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ev[0] = 0; ev[1] = 0; ep[0] = 0; ep[1] = 0; et[0] = ""; et[1] = "";
    do_reset();

    // R3 R5 R7 R8 table walk with gaps (R9) and frame/line flags (R4)
    foreach (VEC[k])
      step(VEC[k][30], VEC[k][29], VEC[k][28], VEC[k][27:24], VEC[k][23:16],
           VEC[k][15:8], VEC[k][7:0], "R3 R5 R8");
    flush();

    // R6 zero payload passes pixels unchanged
    for (int k = 0; k < 6; k++) step(1, k == 0, 0, 0, 255, 255, 40*k + 3, "R6");
    // R7 zero gain passes pixels unchanged
    for (int k = 0; k < 6; k++) step(1, 0, 0, 9, 0, 255, 200 - 30*k, "R7");
    flush();

    // R4 tile walk: 10 lines of 11 pixels, columns and rows wrap past the tile
    for (int y = 0; y < 10; y++)
      for (int x = 0; x < 11; x++)
        step(1, (y == 0 && x == 0), (x == 10), 5 + y, 200, 64 + x, 120, "R4 R5");
    flush();

    // R9 gaps between pixels do not advance the walk
    for (int k = 0; k < 12; k++)
      step(k % 3 != 1, 0, 0, 6, 180, 90, 128, "R9");
    flush();

    // R1 reset mid-stream then the walk restarts at row 0 column 0 (R4)
    step(1, 0, 0, 3, 255, 255, 128, "R8");
    step(1, 0, 0, 3, 255, 255, 128, "R8");
    do_reset();
    for (int k = 0; k < 4; k++) step(1, 0, 0, 13, 140, 150, 128, "R1 R4");
    flush();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule